// File: doc/BRIEF.md
# Radio SPI Command Transaction Engine

This block is an SPI master that runs one command transaction at a time against a 2.4 GHz radio transceiver. A transaction is a single command byte followed by zero to 32 data bytes, all framed by one active-low chip select. The host gives the operation kind, a 5-bit register address or a raw opcode, a byte count and the write bytes. The engine builds the opcode, shifts every byte in SPI mode 0, and returns two things. One is the status byte that the device drives back during the command byte. The other is any bytes read during the data phase.

Requests use a valid/ready handshake. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle, so a request offered at any other time is not taken and has no effect. The host holds `req_valid` and the request fields steady until it sees them accepted. Results need no back-pressure: `done` pulses for one cycle when a transaction ends. From then on, `status` and `rd_data` hold their values until a later transaction overwrites them. The SPI half-period is the `DIV` parameter, counted in system clocks.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` and `done` are 0, and `req_ready` is 1.
- R2: Operation code 1 (register write) sends the opcode 0x20 OR'ed with `req_addr`, then the data bytes. Data byte k is taken from `req_wdata[8k+7:8k]`. Every byte goes out most significant bit first.
- R3: Operation code 0 (register read) sends `req_addr` as the opcode. Operation code 3 (raw read) sends `req_raw` as the opcode. In both, the engine sends 0x00 for each data byte, and data byte k received is returned on `rd_data[8k+7:8k]`.
- R4: Operation codes 2 (raw write) and 3 send `req_raw` unchanged as the opcode. With a count of 0, only the command byte is sent, for example 0xFF, 0xE1 or 0xE2.
- R5: The byte received while the command byte is shifted appears on `status`. It never lands in `rd_data`.
- R6: `spi_cs_n` stays low across the whole transaction. During that window there are exactly 8×(n+1) rising `spi_sck` edges, where n is the number of data bytes.
- R7: `spi_sck` is low whenever chip select is high. `spi_mosi` does not change while `spi_sck` is high, and MISO is sampled on the rising edge.
- R8: Every `spi_sck` level lasts exactly `DIV` clocks. The first rising edge comes `DIV` clocks after chip select falls.
- R9: Chip select stays high for at least `DIV` clocks between transactions.
- R10: `done` is high for exactly one cycle, the first cycle in which chip select is high again after the transaction.
- R11: A request offered while `req_ready` is low is ignored: it starts no transaction and adds no bytes to the one in flight.
- R12: A count above 32 is clamped to 32 data bytes.
- R13: `rd_data` keeps its value after `done` until a later read transaction replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle; request taken when both are high |
| req_op | input | 2 | 0 register read, 1 register write, 2 raw write, 3 raw read |
| req_addr | input | 5 | Register address for operation codes 0 and 1 |
| req_raw | input | 8 | Opcode for operation codes 2 and 3 |
| req_len | input | LEN_W (7) | Number of data bytes (clamped to 32) |
| req_wdata | input | MAX_BYTES×8 (256) | Write bytes; byte k at bits 8k+7:8k |
| busy | output | 1 | Transaction in progress, including the closing gap |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Byte received during the command byte |
| rd_data | output | MAX_BYTES×8 (256) | Read bytes; byte k at bits 8k+7:8k |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench acts as the radio. It checks every byte the engine shifts out against a queue of expected bytes, so an engine that put the wrong opcode on a register read or write, sent stale data instead of 0x00 dummies, or sent bytes least significant bit first shows up as a byte miscompare. A status byte that differs from the read bytes catches an engine that files the command-phase byte into `rd_data` or loses it. Zero-length raw commands and an oversized count target the edges of the byte counter: an off-by-one there adds or drops eight clock edges. A request held high during a transfer must leave no trace, and a second transaction issued straight after `done` has its chip-select gap measured against `DIV`.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    OP_REG_RD = 2'd0,
    OP_REG_WR = 2'd1,
    OP_RAW_WR = 2'd2,
    OP_RAW_RD = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_HOLD,
    ST_GAP
  } eng_state_e;

  localparam logic [7:0] REG_WR_FLAG = 8'h20;
  localparam logic [7:0] DUMMY_BYTE  = 8'h00;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/spi_opcode_map.sv
module spi_opcode_map
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        raw,
  output logic [7:0]        opcode,
  output logic              rd_dir
);
  cmd_op_e op_e;
  assign op_e = cmd_op_e'(op);

  always_comb begin
    opcode = raw;
    rd_dir = 1'b0;
    unique case (op_e)
      OP_REG_RD: begin
        opcode = 8'(addr);
        rd_dir = 1'b1;
      end
      OP_REG_WR: opcode = REG_WR_FLAG | 8'(addr);
      OP_RAW_WR: opcode = raw;
      OP_RAW_RD: begin
        opcode = raw;
        rd_dir = 1'b1;
      end
      default: opcode = raw;
    endcase
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              tick,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BW-1:0]     bit_q;
  logic              sck_q;
  logic              last_bit;

  assign last_bit  = (bit_q == LAST_BIT);
  assign byte_done = tick && active && sck_q && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
    end else if (start) begin
      tx_q  <= load_byte;
      bit_q <= '0;
      sck_q <= 1'b0;
    end else if (tick && active) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_q  <= {rx_q[BYTE_W-2:0], miso};
      end else begin
        sck_q <= 1'b0;
        if (last_bit) begin
          bit_q <= '0;
          tx_q  <= load_byte;
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = tx_q[BYTE_W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_rd_store.sv
module spi_rd_store #(
  parameter int NBYTES = 32,
  parameter int IDXW   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDXW-1:0]     wr_idx,
  input  logic [7:0]          wr_byte,
  output logic [NBYTES*8-1:0] bytes_flat
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (wr_en && wr_idx == IDXW'(g)) begin
        slot_q <= wr_byte;
      end
    end
    assign bytes_flat[g*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int MAX_BYTES = 32,
  parameter int ADDR_W    = 5,
  parameter int LEN_W     = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_op,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [7:0]             req_raw,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [MAX_BYTES*8-1:0] req_wdata,
  output logic                   busy,
  output logic                   done,
  output logic [7:0]             status,
  output logic [MAX_BYTES*8-1:0] rd_data,
  output logic                   spi_cs_n,
  output logic                   spi_sck,
  output logic                   spi_mosi,
  input  logic                   spi_miso
);
  localparam int IDXW = $clog2(MAX_BYTES + 1) + 1;
  localparam logic [IDXW-1:0] MAX_IDX = IDXW'(MAX_BYTES);

  eng_state_e state_q;
  logic                   cs_n_q;
  logic                   done_q;
  logic [7:0]             status_q;
  logic [IDXW-1:0]        len_q;
  logic [IDXW-1:0]        idx_q;
  logic                   rd_q;
  logic [MAX_BYTES*8-1:0] wdata_q;

  logic       accept;
  logic       run;
  logic       tick;
  logic       byte_done;
  logic [7:0] rx_byte;
  logic [7:0] opcode;
  logic       rd_dir;
  logic [7:0] next_data;
  logic [7:0] load_byte;
  logic [IDXW-1:0] len_eff;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign run       = (state_q != ST_IDLE);
  assign req_ready = (state_q == ST_IDLE);
  assign busy      = run;

  assign len_eff = (req_len > LEN_W'(MAX_BYTES)) ? MAX_IDX : IDXW'(req_len);

  spi_opcode_map #(.ADDR_W(ADDR_W)) u_opmap (
    .op     (req_op),
    .addr   (req_addr),
    .raw    (req_raw),
    .opcode (opcode),
    .rd_dir (rd_dir)
  );

  spi_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  // Byte to shift after the one now completing: a dummy on reads, else write data.
  always_comb begin
    next_data = DUMMY_BYTE;
    for (int k = 0; k < MAX_BYTES; k++) begin
      if (!rd_q && idx_q == IDXW'(k)) next_data = wdata_q[k*8 +: 8];
    end
  end

  assign load_byte = accept ? opcode : next_data;

  spi_byte_shifter #(.BYTE_W(8)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .active    (state_q == ST_XFER),
    .tick      (tick),
    .load_byte (load_byte),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  spi_rd_store #(.NBYTES(MAX_BYTES), .IDXW(IDXW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (byte_done && rd_q && idx_q != '0),
    .wr_idx     (idx_q - 1'b1),
    .wr_byte    (rx_byte),
    .bytes_flat (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      status_q <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      rd_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_XFER;
            cs_n_q  <= 1'b0;
            len_q   <= len_eff;
            rd_q    <= rd_dir;
            wdata_q <= req_wdata;
            idx_q   <= '0;
          end
        end
        ST_XFER: begin
          if (byte_done) begin
            if (idx_q == '0) status_q <= rx_byte;
            if (idx_q == len_q) state_q <= ST_HOLD;
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_n = cs_n_q;
  assign done     = done_q;
  assign status   = status_q;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic busy,
  input logic done
);
  localparam int HW = $clog2(DIV + 2) + 1;
  localparam logic [HW-1:0] GSAT = HW'(DIV + 1);

  logic          sck_q;
  logic          cs_q;
  logic [HW-1:0] hcnt;
  logic [HW-1:0] gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      hcnt  <= '0;
      gcnt  <= GSAT;
    end else begin
      sck_q <= spi_sck;
      cs_q  <= spi_cs_n;
      if (spi_sck != sck_q || spi_cs_n != cs_q) hcnt <= '0;
      else if (hcnt != {HW{1'b1}}) hcnt <= hcnt + 1'b1;
      if (!spi_cs_n) gcnt <= '0;
      else if (gcnt < GSAT) gcnt <= gcnt + 1'b1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R7

  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && sck_q) |-> $stable(spi_mosi)); // R7

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck != sck_q) |-> (hcnt == HW'(DIV - 1))); // R8

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && cs_q) |-> (gcnt >= HW'(DIV))); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !cs_q)); // R10

  AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy); // R6
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.DIV(DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_cs_n (spi_cs_n),
  .spi_sck  (spi_sck),
  .spi_mosi (spi_mosi),
  .busy     (busy),
  .done     (done)
);

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
  import spi_cmd_pkg::*;

  localparam int DIV = 4;
  localparam int MAXB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_raw = '0;
  logic [6:0] req_len = '0;
  logic [MAXB*8-1:0] req_wdata = '0;
  logic busy, done;
  logic [7:0] status;
  logic [MAXB*8-1:0] rd_data;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_raw(req_raw), .req_len(req_len),
    .req_wdata(req_wdata), .busy(busy), .done(done), .status(status),
    .rd_data(rd_data), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] resp_mem [0:MAXB];
  logic [7:0] wbuf [0:MAXB-1];
  int rises = 0;
  int cs_falls = 0;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Device model and monitor: pops expected bytes as the engine shifts them out.
  logic pcs = 1'b1, psck = 1'b0;
  logic [7:0] sh_in = '0, sh_out = '0;
  int bitn = 0, bidx = 0, last_rise = -1, cs_rise_cyc = -1;
  initial forever begin
    @(spi_cs_n or spi_sck);
    if (pcs && !spi_cs_n) begin
      cs_falls++;
      if (cs_rise_cyc >= 0) chk("R9 cs high gap ok", 256'(cyc - cs_rise_cyc >= DIV), 256'(1));
      bitn = 0; bidx = 0; last_rise = -1;
      sh_out = resp_mem[0];
      spi_miso = sh_out[7];
    end else if (!pcs && spi_cs_n) begin
      cs_rise_cyc = cyc;
    end else if (!psck && spi_sck && !spi_cs_n) begin
      rises++;
      if (last_rise >= 0) chk("R8 sck period", 256'(cyc - last_rise), 256'(2*DIV));
      last_rise = cyc;
      sh_in = {sh_in[6:0], spi_mosi};
    end else if (psck && !spi_sck && !spi_cs_n) begin
      bitn++;
      if (bitn == 8) begin
        if (exp_q.size() == 0) chk("R11 unexpected extra byte", 256'(sh_in), 256'h1ff);
        else chk("R2/R3/R4 mosi byte", 256'(sh_in), 256'(exp_q.pop_front()));
        bitn = 0;
        bidx++;
        sh_out = (bidx <= MAXB) ? resp_mem[bidx] : 8'h00;
      end else begin
        sh_out = {sh_out[6:0], 1'b0};
      end
      spi_miso = sh_out[7];
    end
    pcs = spi_cs_n;
    psck = spi_sck;
  end

  // Driver: pushes the expected MOSI stream, issues the request, checks results.
  task automatic run_txn(input logic [1:0] op, input logic [4:0] addr, input logic [7:0] raw,
                         input int len, input logic [7:0] st, input string tag);
    int n;
    logic [7:0] opc;
    logic rd;
    int guard;
    n = (len > MAXB) ? MAXB : len;
    rd = (op == 2'd0) || (op == 2'd3);
    case (op)
      2'd0: opc = {3'b000, addr};
      2'd1: opc = 8'h20 | {3'b000, addr};
      default: opc = raw;
    endcase
    exp_q.push_back(opc);
    for (int i = 0; i < n; i++) exp_q.push_back(rd ? 8'h00 : wbuf[i]);
    resp_mem[0] = st;
    for (int i = 0; i < MAXB; i++) req_wdata[i*8 +: 8] = wbuf[i];
    rises = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = addr; req_raw = raw; req_len = 7'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " R10 done seen with cs high"}, 256'({done, spi_cs_n, spi_sck}), 256'(3'b110));
    chk({tag, " R6 sck rises in frame"}, 256'(rises), 256'(8*(n+1)));
    chk({tag, " R2/R3/R4 all bytes sent"}, 256'(exp_q.size()), 256'(0));
    chk({tag, " R5 status"}, 256'(status), 256'(st));
    if (rd) for (int i = 0; i < n; i++)
      chk({tag, " R3 read byte"}, 256'(rd_data[i*8 +: 8]), 256'(resp_mem[i+1]));
    @(negedge clk);
    chk({tag, " R10 done single cycle"}, 256'(done), 256'(0));
  endtask

  initial begin
    for (int i = 0; i <= MAXB; i++) resp_mem[i] = 8'h00;
    for (int i = 0; i < MAXB; i++) wbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 256'({spi_cs_n, spi_sck, busy, done, req_ready}), 256'(5'b10001));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 256'({spi_cs_n, spi_sck, busy, done, req_ready}), 256'(5'b10001));

    // R2 single register write
    wbuf[0] = 8'h6E;
    run_txn(2'd1, 5'h05, 8'h00, 1, 8'h0E, "wr1");

    // R2 burst register write, five bytes under one chip select (R6)
    wbuf[0] = 8'h71; wbuf[1] = 8'h9A; wbuf[2] = 8'h03; wbuf[3] = 8'hC4; wbuf[4] = 8'h55;
    run_txn(2'd1, 5'h10, 8'h00, 5, 8'h2E, "wr5");

    // R3 register read with status distinct from data (R5)
    resp_mem[1] = 8'h3C;
    run_txn(2'd0, 5'h07, 8'h00, 1, 8'h4E, "rd1");

    // R3/R4 raw read payload, four bytes
    resp_mem[1] = 8'hDE; resp_mem[2] = 8'hAD; resp_mem[3] = 8'hBE; resp_mem[4] = 8'hEF;
    run_txn(2'd3, 5'h00, 8'h61, 4, 8'h40, "rdpl");

    // R13 read data held while idle and across a write
    repeat (30) @(negedge clk);
    chk("R13 rd held idle", 256'(rd_data[31:0]), 256'(32'hEFBEADDE));
    wbuf[0] = 8'h11;
    run_txn(2'd1, 5'h01, 8'h00, 1, 8'h0E, "wrhold");
    chk("R13 rd held after write", 256'(rd_data[31:0]), 256'(32'hEFBEADDE));

    // R4 zero-length raw commands, back to back (R9)
    run_txn(2'd2, 5'h00, 8'hFF, 0, 8'h0E, "nop");
    run_txn(2'd2, 5'h00, 8'hE1, 0, 8'h1E, "flushtx");

    // R11 request offered during a transfer is ignored
    begin
      int falls_before;
      wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
      fork
        run_txn(2'd2, 5'h00, 8'hA0, 2, 8'h0E, "busyreq");
        begin
          @(negedge clk);
          while (!busy) @(negedge clk);
          repeat (3) @(negedge clk);
          req_op = 2'd2; req_raw = 8'hE2; req_len = 7'd0; req_valid = 1'b1;
          repeat (5) @(negedge clk);
          req_valid = 1'b0;
        end
      join
      falls_before = cs_falls;
      repeat (40) @(negedge clk);
      chk("R11 no extra transaction", 256'(cs_falls), 256'(falls_before));
      chk("R11 engine idle", 256'({busy, spi_cs_n}), 256'(2'b01));
    end

    // R12 oversized count clamps to 32 data bytes
    for (int i = 0; i < MAXB; i++) wbuf[i] = 8'(i * 7 + 1);
    run_txn(2'd2, 5'h00, 8'hA0, 40, 8'h0E, "clamp R12");

    // R3/R12 full 32-byte read
    for (int i = 1; i <= MAXB; i++) resp_mem[i] = 8'(255 - i * 3);
    run_txn(2'd3, 5'h00, 8'h61, 32, 8'h40, "rd32");

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule